// File: doc/BRIEF.md
# Completion Signal Timeout Timer

This block watches a memory-card host controller while it waits for the card's completion signal. A transfer ends in one of two ways. For a data command, the wait opens once the data phase has finished, or once the busy phase has finished when the command has one. For an ATA command that moves no data, the wait opens as soon as the response has finished. From then on the block counts master-clock cycles. If the completion signal does not arrive within the programmed limit, the block raises a sticky error flag.

The limit is the product of a 4-bit base count and a multiplier. A 3-bit selector picks the multiplier from a fixed, non-uniform table of powers of two. Hardware does not build the product. A prescaler divides the clock by the selected multiplier, and a small counter compares its ticks against the base count. A configuration byte holds both fields. The byte accepts writes only while the write-protect input is low.

Top module: `cst_timer`

## Requirements
- R1: After reset, `timeout_err` is 0, `waiting` is 0 and `cfg_rdata` is 0.
- R2: A write with `wp_en` low loads the configuration. Bits 3:0 hold the base count and bits 6:4 hold the multiplier selector. Bit 7 always reads 0. `cfg_rdata` shows the new value from the cycle after the write.
- R3: A write while `wp_en` is high is ignored, and `cfg_rdata` keeps its previous value.
- R4: The limit L is the base count times a multiplier chosen by the selector: 0→1, 1→16, 2→128, 3→256, 4→1024, 5→4096, 6→65536, 7→1048576. The clock edge that samples a start event is edge 0. With no completion, `timeout_err` rises after edge L and `waiting` falls after the same edge.
- R5: For a data command, `data_end` opens the wait when `busy_phase` is low. When `busy_phase` is high, `data_end` is ignored and `busy_end` opens the wait instead.
- R6: `resp_end` opens the wait only when `ata_nodata` is high. When `ata_nodata` is low, `resp_end` is ignored.
- R7: If `cmpl_in` is high on any edge from 1 to L while waiting, the wait stops and clears, and no error is raised. This includes edge L itself. A completion after edge L does not clear an error that has already been raised.
- R8: A base count of 0 raises the error after edge 1, whatever the selector.
- R9: `timeout_err` stays high until an edge that samples `sts_rd` or `err_clr` high. A timeout raised on the same edge wins over the clear.
- R10: `waiting` is high from the edge after a start event until completion or timeout. A new start event while waiting restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| wp_en | input | 1 | Write protection enable |
| cfg_rdata | output | 8 | Current configuration value |
| data_end | input | 1 | Pulse: data phase finished |
| busy_phase | input | 1 | Current data command has a busy phase |
| busy_end | input | 1 | Pulse: busy phase finished |
| resp_end | input | 1 | Pulse: response finished |
| ata_nodata | input | 1 | Current command is a non-data ATA command |
| cmpl_in | input | 1 | Completion signal from the card |
| sts_rd | input | 1 | Status read strobe (clears the error) |
| err_clr | input | 1 | Explicit error clear strobe |
| waiting | output | 1 | Wait window is open |
| timeout_err | output | 1 | Sticky completion timeout error |

## Verification
The bench sweeps every multiplier code at small base counts and looks for the error exactly one edge after the last cycle below L. An entry off by one in the table, or a prescaler wrap off by one, shows up as an error one or many cycles early or late. Completion is placed one edge before L, exactly at L and one edge after L. A design that let the timeout win at edge L, or that cleared the error on a late completion, fails these cases. The bench also checks the ignored start pulses (data end during a busy phase, a response without the ATA flag), the base-zero case and writes under protection, each of which a careless decoder would let through.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int BASE_W = 4;
  localparam int SEL_W  = 3;
  localparam int CFG_W  = 8;
  localparam int PRE_W  = 20;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
  } cst_cfg_t;

  // power of two for each selector code
  function automatic int unsigned mult_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 4;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 10;
      3'd5:    return 12;
      3'd6:    return 16;
      default: return 20;
    endcase
  endfunction

  // last prescaler value before a tick: multiplier minus one
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] one_sh;
    one_sh = {{PRE_W{1'b0}}, 1'b1} << mult_shift(sel);
    return one_sh[PRE_W-1:0] - PRE_W'(1);
  endfunction
endpackage

// File: rtl/cst_cfg_reg.sv
module cst_cfg_reg
  import cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             protect,
  output cst_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             wr_taken
);
  localparam int USED_W = BASE_W + SEL_W;

  assign wr_taken = wr && !protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= '0;
    else if (wr_taken) cfg <= cst_cfg_t'(wdata[USED_W-1:0]);
  end

  assign rdata = {{(CFG_W-USED_W){1'b0}}, cfg};
endmodule

// File: rtl/cst_start_sel.sv
module cst_start_sel (
  input  logic data_end,
  input  logic busy_phase,
  input  logic busy_end,
  input  logic resp_end,
  input  logic ata_nodata,
  output logic start_data,
  output logic start_ata,
  output logic start_evt
);
  // a data transfer ends after the busy phase when there is one
  assign start_data = busy_phase ? busy_end : data_end;
  assign start_ata  = resp_end && ata_nodata;
  assign start_evt  = start_data || start_ata;
endmodule

// File: rtl/cst_wait_cnt.sv
module cst_wait_cnt
  import cst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [BASE_W-1:0] base,
  input  logic [SEL_W-1:0]  sel,
  output logic              pre_wrap,
  output logic              limit_hit
);
  logic [PRE_W-1:0]  pre_q;
  logic [BASE_W-1:0] tick_q;
  logic [PRE_W-1:0]  pre_end;

  assign pre_end  = pre_last(sel);
  assign pre_wrap = (pre_q == pre_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart || !run) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      tick_q <= tick_q + BASE_W'(1);
    end else begin
      pre_q  <= pre_q + PRE_W'(1);
    end
  end

  // the edge that is about to complete cycle number base*mult
  assign limit_hit = run &&
                     ((base == '0) || (pre_wrap && (tick_q == base - BASE_W'(1))));
endmodule

// File: rtl/cst_timer.sv
module cst_timer
  import cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             wp_en,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             data_end,
  input  logic             busy_phase,
  input  logic             busy_end,
  input  logic             resp_end,
  input  logic             ata_nodata,
  input  logic             cmpl_in,
  input  logic             sts_rd,
  input  logic             err_clr,
  output logic             waiting,
  output logic             timeout_err
);
  cst_cfg_t cfg;
  logic     wr_taken;
  logic     start_data, start_ata, start_evt;
  logic     pre_wrap, limit_hit;
  logic     done_ok, timeout_fire, err_wipe;

  cst_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .protect(wp_en), .cfg(cfg), .rdata(cfg_rdata), .wr_taken(wr_taken)
  );

  cst_start_sel u_start (
    .data_end(data_end), .busy_phase(busy_phase), .busy_end(busy_end),
    .resp_end(resp_end), .ata_nodata(ata_nodata),
    .start_data(start_data), .start_ata(start_ata), .start_evt(start_evt)
  );

  cst_wait_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(start_evt), .run(waiting),
    .base(cfg.base), .sel(cfg.sel), .pre_wrap(pre_wrap), .limit_hit(limit_hit)
  );

  // completion wins over a limit reached on the same edge
  assign done_ok      = waiting && cmpl_in && !start_evt;
  assign timeout_fire = waiting && !cmpl_in && limit_hit && !start_evt;
  assign err_wipe     = sts_rd || err_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        waiting <= 1'b0;
    else if (start_evt)                waiting <= 1'b1;
    else if (done_ok || timeout_fire)  waiting <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            timeout_err <= 1'b0;
    else if (timeout_fire) timeout_err <= 1'b1;
    else if (err_wipe)     timeout_err <= 1'b0;
  end
endmodule

// File: rtl/cst_timer_chk.sv
module cst_timer_chk
  import cst_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             wp_en,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             start_evt,
  input logic             start_ata,
  input logic             done_ok,
  input logic             timeout_fire,
  input logic             cmpl_in,
  input logic             sts_rd,
  input logic             err_clr,
  input logic             waiting,
  input logic             timeout_err
);
  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wp_en) |=> $stable(cfg_rdata));

  // R2
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_W-1] == 1'b0);

  // R6
  ata_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ata |=> waiting);

  // R7
  cmpl_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !timeout_err) |=> (!timeout_err && !waiting));

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !sts_rd && !err_clr) |=> timeout_err);

  // R4
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($past(waiting) && !$past(cmpl_in)));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_fire && !start_evt) |=> !waiting);
endmodule

bind cst_timer cst_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wp_en(wp_en),
  .cfg_rdata(cfg_rdata), .start_evt(start_evt), .start_ata(start_ata),
  .done_ok(done_ok), .timeout_fire(timeout_fire), .cmpl_in(cmpl_in),
  .sts_rd(sts_rd), .err_clr(err_clr), .waiting(waiting),
  .timeout_err(timeout_err)
);

// File: tb/cst_timer_bench.sv
module cst_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 0, wp_en = 0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       data_end = 0, busy_phase = 0, busy_end = 0;
  logic       resp_end = 0, ata_nodata = 0, cmpl_in = 0;
  logic       sts_rd = 0, err_clr = 0;
  logic       waiting, timeout_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cst_timer u_cst_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .wp_en(wp_en), .cfg_rdata(cfg_rdata), .data_end(data_end),
    .busy_phase(busy_phase), .busy_end(busy_end), .resp_end(resp_end),
    .ata_nodata(ata_nodata), .cmpl_in(cmpl_in), .sts_rd(sts_rd),
    .err_clr(err_clr), .waiting(waiting), .timeout_err(timeout_err)
  );

  function automatic int mult_of(input int sel);
    int tbl [8] = '{1, 16, 128, 256, 1024, 4096, 65536, 1048576};
    return tbl[sel];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic prot);
    @(negedge clk); cfg_wdata = d; wp_en = prot; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0; wp_en = 0;
  endtask

  // kind 0: data no busy, 1: busy end, 2: ATA response
  task automatic start(input int kind);
    @(negedge clk);
    case (kind)
      0: begin busy_phase = 0; data_end = 1; end
      1: begin busy_phase = 1; busy_end = 1; end
      default: begin ata_nodata = 1; resp_end = 1; end
    endcase
    @(negedge clk);
    data_end = 0; busy_end = 0; resp_end = 0; ata_nodata = 0; busy_phase = 0;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  // called at the negedge right after the start edge
  task automatic expect_timeout(input int lim, input string req);
    repeat (lim - 1) @(negedge clk);
    check({req, " no error before L"}, timeout_err, 0);
    @(negedge clk);
    check({req, " error at L"}, timeout_err, 1);
    check({req, " wait closed"}, waiting, 0);
  endtask

  task automatic t_reset();
    check("R1 err", timeout_err, 0);
    check("R1 waiting", waiting, 0);
    check("R1 cfg", cfg_rdata, 0);
  endtask

  task automatic t_cfg_access();
    wr_cfg(8'hFF, 1'b0);
    check("R2 layout, bit7 zero", cfg_rdata, 8'h7F);
    wr_cfg(8'h21, 1'b0);
    check("R2 write", cfg_rdata, 8'h21);
    wr_cfg(8'h53, 1'b1);
    check("R3 protected write ignored", cfg_rdata, 8'h21);
  endtask

  task automatic t_mult_sweep();
    for (int s = 0; s < 7; s++) begin
      wr_cfg(8'((s << 4) | 1), 1'b0);
      start(0);
      expect_timeout(mult_of(s), $sformatf("R4 sel %0d", s));
      clear_err();
    end
    wr_cfg(8'h0F, 1'b0);
    start(0);
    expect_timeout(15, "R4 base 15 x1");
    clear_err();
    wr_cfg(8'h23, 1'b0);
    start(0);
    expect_timeout(384, "R4 base 3 x128");
    clear_err();
    wr_cfg(8'h71, 1'b0);
    start(0);
    repeat (70000) @(negedge clk);
    check("R4 sel 7 not yet expired", timeout_err, 0);
    check("R4 sel 7 still waiting", waiting, 1);
    @(negedge clk); cmpl_in = 1;
    @(negedge clk); cmpl_in = 0;
    check("R7 sel 7 completion closes", waiting, 0);
    check("R7 sel 7 no error", timeout_err, 0);
  endtask

  task automatic t_starts();
    wr_cfg(8'h14, 1'b0); // L = 64
    @(negedge clk); busy_phase = 1; data_end = 1;
    @(negedge clk); data_end = 0;
    check("R5 data_end ignored in busy phase", waiting, 0);
    busy_end = 1;
    @(negedge clk); busy_end = 0; busy_phase = 0;
    check("R5 busy_end opens wait", waiting, 1);
    expect_timeout(64, "R5 busy path");
    clear_err();
    @(negedge clk); resp_end = 1; ata_nodata = 0;
    @(negedge clk); resp_end = 0;
    check("R6 plain response ignored", waiting, 0);
    start(2);
    check("R6 ATA response opens wait", waiting, 1);
    expect_timeout(64, "R6 ATA path");
    clear_err();
  endtask

  task automatic t_cmpl_edges();
    wr_cfg(8'h13, 1'b0); // L = 48
    start(0);
    repeat (46) @(negedge clk);
    cmpl_in = 1;
    @(negedge clk); cmpl_in = 0;
    check("R7 completion at L-1 closes", waiting, 0);
    repeat (60) @(negedge clk);
    check("R7 completion at L-1 no error", timeout_err, 0);
    start(0);
    repeat (47) @(negedge clk);
    cmpl_in = 1;
    @(negedge clk); cmpl_in = 0;
    check("R7 completion at L no error", timeout_err, 0);
    check("R7 completion at L closes", waiting, 0);
    start(0);
    repeat (48) @(negedge clk);
    check("R7 error at L", timeout_err, 1);
    cmpl_in = 1;
    @(negedge clk); cmpl_in = 0;
    check("R7 late completion keeps error", timeout_err, 1);
    repeat (5) @(negedge clk);
    check("R9 error sticky", timeout_err, 1);
    @(negedge clk); sts_rd = 1;
    @(negedge clk); sts_rd = 0;
    check("R9 status read clears", timeout_err, 0);
  endtask

  task automatic t_zero_and_restart();
    wr_cfg(8'h60, 1'b0); // base 0, sel 6
    start(1);
    check("R8 no error right after start", timeout_err, 0);
    @(negedge clk);
    check("R8 base zero error at edge 1", timeout_err, 1);
    clear_err();
    wr_cfg(8'h02, 1'b0); // L = 2
    start(0);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    check("R9 timeout wins over clear", timeout_err, 1);
    clear_err();
    wr_cfg(8'h05, 1'b0); // L = 5
    start(0);
    repeat (3) @(negedge clk);
    start(0);
    repeat (4) @(negedge clk);
    check("R10 restart no early error", timeout_err, 0);
    check("R10 restart still waiting", waiting, 1);
    @(negedge clk);
    check("R10 restart error at new L", timeout_err, 1);
    clear_err();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    summary();
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cfg_access();
    t_mult_sweep();
    t_starts();
    t_cmpl_edges();
    t_zero_and_restart();
    summary();
  end
endmodule